// File: doc/BRIEF.md
# Automatic Temperature Sensor Poll Controller

This block runs a temperature-sensor converter on its own. Once automatic polling is switched on, it waits a programmable number of clock cycles, starts one conversion over a start/done handshake, and stores the 12-bit code that comes back. Each stored code is compared against two programmable thresholds. The alarm threshold feeds a maskable interrupt. The shutdown threshold feeds an overtemperature output, which can also be routed to a dedicated pin.

The converter code falls as the die heats up. A sample therefore counts as hot when its code is at or below a threshold. Each comparison goes through its own debounce counter, so a flag is raised only after a programmable run of consecutive hot samples. While the most recent sample is at or above the alarm temperature, the block polls with a second, shorter period. With polling off, software can start single conversions by hand. A simple word-addressed register port gives access to the thresholds, periods, debounce counts, enables, pending flags and the last result.

Top module: `tsense_poll_ctrl`

## Requirements
- R1: After reset, the normal period (address 1) reads 1000 and the hot period (address 2) reads 100. Both debounce counts (addresses 5 and 6) read 10. The control (address 0), enable (address 7) and pending (address 8) registers read 0. irq, ovt_rst, ovt_pin and sns_start are low.
- R2: Automatic polling runs while control bit 0 (auto enable) and bit 5 (channel select) are both set. After a conversion completes with a cold sample, the next sns_start comes exactly the normal period later, counted in cycles from the cycle in which sns_done was high.
- R3: When the last sample's code is at or below the alarm threshold (address 3), the next sns_start comes the hot period later instead.
- R4: Address 9 returns the last converted code. Writing control bit 8 while control bit 0 is clear starts exactly one conversion. While control bit 0 is set, control bit 8 has no effect.
- R5: A sample counts toward a threshold when its code is less than or equal to that threshold. A code one above the threshold counts as cold.
- R6: Pending bit 1 (alarm) is set on the sample that completes the alarm debounce count (address 5) of consecutive hot samples. Any cold sample restarts the count from zero.
- R7: After an alarm has been flagged, further hot samples do not set pending bit 1 again. The count re-arms only after a cold sample.
- R8: Pending bit 5 is set after the shutdown debounce count (address 6) of consecutive samples at or below the shutdown threshold (address 4). ovt_rst equals pending bit 5. ovt_pin equals pending bit 5 AND enable bit 5.
- R9: irq = (pending bit 1 AND enable bit 1) OR (pending bit 5 AND enable bit 5). Writing 1 to a pending bit clears it.
- R10: Clearing control bit 0 during a conversion lets that conversion finish. Control bit 16 (busy) reads 1 until sns_done arrives, and no further conversion starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; periods are counted in its cycles |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sns_start | output | 1 | One-cycle conversion start to the sensor |
| sns_done | input | 1 | Conversion finished; code valid this cycle |
| sns_code | input | 12 | Converted code |
| irq | output | 1 | Masked interrupt |
| ovt_rst | output | 1 | Overtemperature request to chip reset |
| ovt_pin | output | 1 | Overtemperature routed to the external pin |

## Verification
A fault in the period timer or in the hot-period selector shows up at the next sns_start, one period after the completing sns_done. The bench compares that spacing against the code it has just returned. A debounce counter that holds a wrong value appears as a pending bit, and so as irq or ovt_rst, rising one sample early or late, or a second time within a single excursion. That is visible on the clock edge that captures the offending sample. A busy flag that is out of step shows either in the control readback or as a start while polling is off.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
   localparam int REG_ADDR_W = 4;

   typedef enum logic [REG_ADDR_W-1:0] {
      A_CTRL    = 4'd0,
      A_PNORM   = 4'd1,
      A_PHOT    = 4'd2,
      A_THR_ALM = 4'd3,
      A_THR_SHT = 4'd4,
      A_DEB_ALM = 4'd5,
      A_DEB_SHT = 4'd6,
      A_IEN     = 4'd7,
      A_PEND    = 4'd8,
      A_DATA    = 4'd9
   } reg_addr_t;

   localparam int CTRL_AUTO_BIT = 0;
   localparam int CTRL_CH_BIT   = 5;
   localparam int CTRL_MAN_BIT  = 8;
   localparam int CTRL_BUSY_BIT = 16;
   localparam int FLAG_ALM_BIT  = 1;
   localparam int FLAG_SHT_BIT  = 5;

   // comparator channel index: 0 = alarm, 1 = shutdown
   localparam int N_CMP = 2;

   typedef enum logic {SCH_IDLE, SCH_WAIT} sch_state_t;
endpackage

// File: rtl/tsp_debounce.sv
module tsp_debounce #(
   parameter int DEB_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic             hot,
   input  logic [DEB_W-1:0] lim,
   output logic             fire
);
   logic [DEB_W-1:0] cnt;
   logic [DEB_W-1:0] lim_eff;

   assign lim_eff = (lim == '0) ? DEB_W'(1) : lim;
   assign fire    = smp_vld && hot && (cnt < lim_eff) && ((cnt + DEB_W'(1)) == lim_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (smp_vld) begin
         if (!hot)
            cnt <= '0;
         else if (cnt < lim_eff)
            cnt <= cnt + DEB_W'(1);
      end
   end

   // R6
   cold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld && !hot |=> cnt == '0);
   // R7
   fire_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> cnt == $past(lim_eff));
endmodule

// File: rtl/tsp_sched.sv
module tsp_sched import tsp_pkg::*; #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             man_go,
   input  logic [PER_W-1:0] per_norm,
   input  logic [PER_W-1:0] per_hot,
   input  logic             hot_smp,
   input  logic             sns_done,
   output logic             sns_start,
   output logic             busy,
   output logic             smp_vld
);
   sch_state_t       state;
   logic [PER_W-1:0] timer;
   logic             hot_q;
   logic [PER_W-1:0] per_sel;
   logic [PER_W-1:0] per_last;
   logic             auto_fire;

   assign per_sel   = hot_q ? per_hot : per_norm;
   assign per_last  = (per_sel == '0) ? '0 : per_sel - PER_W'(1);
   assign auto_fire = run && (timer >= per_last);
   assign sns_start = (state == SCH_IDLE) && (auto_fire || man_go);
   assign busy      = (state == SCH_WAIT);
   assign smp_vld   = busy && sns_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SCH_IDLE;
         timer <= '0;
         hot_q <= 1'b0;
      end else begin
         unique case (state)
            SCH_IDLE: begin
               if (sns_start) begin
                  state <= SCH_WAIT;
                  timer <= '0;
               end else if (run) begin
                  timer <= timer + PER_W'(1);
               end else begin
                  timer <= '0;
               end
            end
            SCH_WAIT: begin
               if (sns_done) begin
                  state <= SCH_IDLE;
                  timer <= '0;
                  hot_q <= hot_smp;
               end
            end
            default: state <= SCH_IDLE;
         endcase
      end
   end

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sns_start |=> busy);
   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !sns_done |=> busy);
endmodule

// File: rtl/tsp_regs.sv
module tsp_regs import tsp_pkg::*; #(
   parameter int DATA_W       = 32,
   parameter int CODE_W       = 12,
   parameter int PER_W        = 16,
   parameter int DEB_W        = 8,
   parameter int PER_NORM_RST = 1000,
   parameter int PER_HOT_RST  = 100,
   parameter int ALM_DEB_RST  = 10,
   parameter int SHT_DEB_RST  = 10,
   parameter int ALM_THR_RST  = 3550,
   parameter int SHT_THR_RST  = 3437
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [REG_ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DATA_W-1:0]            rdata,
   input  logic                         busy,
   input  logic                         smp_vld,
   input  logic [CODE_W-1:0]            smp_code,
   input  logic [N_CMP-1:0]             fire,
   output logic                         run,
   output logic                         man_go,
   output logic [PER_W-1:0]             per_norm,
   output logic [PER_W-1:0]             per_hot,
   output logic [N_CMP-1:0][CODE_W-1:0] thr,
   output logic [N_CMP-1:0][DEB_W-1:0]  deb,
   output logic [N_CMP-1:0]             ien,
   output logic [N_CMP-1:0]             pend
);
   localparam int FLAG_POS [N_CMP] = '{FLAG_ALM_BIT, FLAG_SHT_BIT};

   logic              auto_q;
   logic              ch_q;
   logic [CODE_W-1:0] data_q;

   assign run    = auto_q && ch_q;
   assign man_go = we && (addr == A_CTRL) && wdata[CTRL_MAN_BIT] && !auto_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_q   <= 1'b0;
         ch_q     <= 1'b0;
         per_norm <= PER_W'(PER_NORM_RST);
         per_hot  <= PER_W'(PER_HOT_RST);
         thr[0]   <= CODE_W'(ALM_THR_RST);
         thr[1]   <= CODE_W'(SHT_THR_RST);
         deb[0]   <= DEB_W'(ALM_DEB_RST);
         deb[1]   <= DEB_W'(SHT_DEB_RST);
         ien      <= '0;
      end else if (we) begin
         case (addr)
            A_CTRL: begin
               auto_q <= wdata[CTRL_AUTO_BIT];
               ch_q   <= wdata[CTRL_CH_BIT];
            end
            A_PNORM:   per_norm <= wdata[PER_W-1:0];
            A_PHOT:    per_hot  <= wdata[PER_W-1:0];
            A_THR_ALM: thr[0]   <= wdata[CODE_W-1:0];
            A_THR_SHT: thr[1]   <= wdata[CODE_W-1:0];
            A_DEB_ALM: deb[0]   <= wdata[DEB_W-1:0];
            A_DEB_SHT: deb[1]   <= wdata[DEB_W-1:0];
            A_IEN: begin
               ien[0] <= wdata[FLAG_ALM_BIT];
               ien[1] <= wdata[FLAG_SHT_BIT];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (smp_vld)
         data_q <= smp_code;
   end

   for (genvar i = 0; i < N_CMP; i++) begin : g_pend
      logic p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            p_q <= 1'b0;
         else if (fire[i])
            p_q <= 1'b1;
         else if (we && (addr == A_PEND) && wdata[FLAG_POS[i]])
            p_q <= 1'b0;
      end
      assign pend[i] = p_q;

      // R6
      fire_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fire[i] |=> pend[i]);
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: begin
            rdata[CTRL_AUTO_BIT] = auto_q;
            rdata[CTRL_CH_BIT]   = ch_q;
            rdata[CTRL_BUSY_BIT] = busy;
         end
         A_PNORM:   rdata[PER_W-1:0]  = per_norm;
         A_PHOT:    rdata[PER_W-1:0]  = per_hot;
         A_THR_ALM: rdata[CODE_W-1:0] = thr[0];
         A_THR_SHT: rdata[CODE_W-1:0] = thr[1];
         A_DEB_ALM: rdata[DEB_W-1:0]  = deb[0];
         A_DEB_SHT: rdata[DEB_W-1:0]  = deb[1];
         A_IEN: begin
            rdata[FLAG_ALM_BIT] = ien[0];
            rdata[FLAG_SHT_BIT] = ien[1];
         end
         A_PEND: begin
            rdata[FLAG_ALM_BIT] = pend[0];
            rdata[FLAG_SHT_BIT] = pend[1];
         end
         A_DATA:    rdata[CODE_W-1:0] = data_q;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/tsense_poll_ctrl.sv
module tsense_poll_ctrl import tsp_pkg::*; #(
   parameter int DATA_W       = 32,
   parameter int CODE_W       = 12,
   parameter int PER_W        = 16,
   parameter int DEB_W        = 8,
   parameter int PER_NORM_RST = 1000,
   parameter int PER_HOT_RST  = 100,
   parameter int ALM_DEB_RST  = 10,
   parameter int SHT_DEB_RST  = 10,
   parameter int ALM_THR_RST  = 3550,
   parameter int SHT_THR_RST  = 3437
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic                  sns_start,
   input  logic                  sns_done,
   input  logic [CODE_W-1:0]     sns_code,
   output logic                  irq,
   output logic                  ovt_rst,
   output logic                  ovt_pin
);
   if (DATA_W <= CTRL_BUSY_BIT) begin : g_bad_data_w
      $error("DATA_W must hold the busy flag");
   end
   if (CODE_W > DATA_W || PER_W > DATA_W || DEB_W > DATA_W) begin : g_bad_field_w
      $error("register fields must fit DATA_W");
   end
   if (PER_NORM_RST >= (1 << PER_W) || PER_HOT_RST >= (1 << PER_W)) begin : g_bad_per
      $error("period reset values exceed PER_W");
   end

   logic                         run;
   logic                         man_go;
   logic                         busy;
   logic                         smp_vld;
   logic [PER_W-1:0]             per_norm;
   logic [PER_W-1:0]             per_hot;
   logic [N_CMP-1:0][CODE_W-1:0] thr;
   logic [N_CMP-1:0][DEB_W-1:0]  deb;
   logic [N_CMP-1:0]             ien;
   logic [N_CMP-1:0]             pend;
   logic [N_CMP-1:0]             hot;
   logic [N_CMP-1:0]             fire;

   tsp_regs #(
      .DATA_W(DATA_W), .CODE_W(CODE_W), .PER_W(PER_W), .DEB_W(DEB_W),
      .PER_NORM_RST(PER_NORM_RST), .PER_HOT_RST(PER_HOT_RST),
      .ALM_DEB_RST(ALM_DEB_RST), .SHT_DEB_RST(SHT_DEB_RST),
      .ALM_THR_RST(ALM_THR_RST), .SHT_THR_RST(SHT_THR_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy(busy), .smp_vld(smp_vld), .smp_code(sns_code),
      .fire(fire), .run(run), .man_go(man_go), .per_norm(per_norm),
      .per_hot(per_hot), .thr(thr), .deb(deb), .ien(ien), .pend(pend)
   );

   tsp_sched #(.PER_W(PER_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .run(run), .man_go(man_go),
      .per_norm(per_norm), .per_hot(per_hot), .hot_smp(hot[0]),
      .sns_done(sns_done), .sns_start(sns_start), .busy(busy), .smp_vld(smp_vld)
   );

   for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      // lower code means hotter die
      assign hot[i] = (sns_code <= thr[i]);
      tsp_debounce #(.DEB_W(DEB_W)) u_deb (
         .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .hot(hot[i]),
         .lim(deb[i]), .fire(fire[i])
      );
   end

   assign irq     = |(pend & ien);
   assign ovt_rst = pend[1];
   assign ovt_pin = pend[1] && ien[1];

   // R8
   pin_implies_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovt_pin |-> ovt_rst);
endmodule

// File: tb/tsense_poll_ctrl_tb.sv
module tsense_poll_ctrl_tb_top;
   localparam int ALM = 3550;
   localparam int PN  = 20;
   localparam int PH  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sns_start;
   logic        sns_done = 1'b0;
   logic [11:0] sns_code = '0;
   logic        irq, ovt_rst, ovt_pin;

   int total = 0;
   int fails = 0;
   int cyc = 0;
   int last_done = 0;
   int done_cnt = 0;
   int start_cnt = 0;
   bit finished = 0;
   logic [11:0] sens_q [$];
   int gap_q [$];

   always #5 clk = ~clk;

   tsense_poll_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sns_start(sns_start),
      .sns_done(sns_done), .sns_code(sns_code), .irq(irq),
      .ovt_rst(ovt_rst), .ovt_pin(ovt_pin)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // driver: queue the sensor code and the expected gap to the next start
   task automatic sample(input logic [11:0] code, input int next_gap);
      int n;
      sens_q.push_back(code);
      gap_q.push_back(next_gap >= 0 ? next_gap : ((int'(code) <= ALM) ? PH : PN));
      n = done_cnt;
      wait (done_cnt != n);
      @(negedge clk); #1;
   endtask

   // sensor model
   initial begin
      forever begin
         @(negedge clk); #1;
         if (sns_start) begin
            repeat (3) @(negedge clk);
            sns_code = (sens_q.size() > 0) ? sens_q.pop_front() : 12'd3700;
            sns_done = 1'b1;
            @(negedge clk);
            sns_done = 1'b0;
         end
      end
   end

   // monitor: start spacing scoreboard
   initial begin
      forever begin
         @(negedge clk); #1;
         cyc++;
         if (sns_done) begin
            last_done = cyc;
            done_cnt++;
         end
         if (sns_start) begin
            start_cnt++;
            if (gap_q.size() == 0) chk("R2 unexpected start", 1, 0);
            else begin
               int g;
               g = gap_q.pop_front();
               if (g > 0) chk("R2/R3 start spacing", cyc - last_done, g);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; fails++;
         $display("FAIL watchdog (all R): actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int sc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      rd(4'd1, d); chk("R1 normal period", d, 1000);
      rd(4'd2, d); chk("R1 hot period", d, 100);
      rd(4'd5, d); chk("R1 alarm debounce", d, 10);
      rd(4'd6, d); chk("R1 shutdown debounce", d, 10);
      rd(4'd0, d); chk("R1 control", d, 0);
      rd(4'd7, d); chk("R1 enables", d, 0);
      rd(4'd8, d); chk("R1 pending", d, 0);
      chk("R1 outputs", {sns_start, irq, ovt_rst, ovt_pin}, 0);

      wr(4'd1, PN); wr(4'd2, PH); wr(4'd5, 3); wr(4'd6, 2);

      // R4 manual conversion
      gap_q.push_back(0);
      sens_q.push_back(12'd3650);
      gap_q.push_back(0);
      sc = done_cnt;
      wr(4'd0, 32'h100);
      wait (done_cnt != sc);
      @(negedge clk); #1;
      rd(4'd9, d); chk("R4 manual result", d, 3650);
      chk("R4 one manual start", start_cnt, 1);

      wr(4'd0, 32'h21);
      sample(12'd3700, -1);
      rd(4'd9, d); chk("R4 data register", d, 3700);
      // R4 manual bit ignored while automatic
      sc = start_cnt;
      wr(4'd0, 32'h121);
      chk("R4 manual ignored in auto", start_cnt, sc);

      sample(12'd3550, -1);                  // R5 equal counts hot, R3 hot gap
      sample(12'd3551, -1);                  // R5 one above is cold
      rd(4'd8, d); chk("R5 boundary no alarm", d, 0);
      sample(12'd3550, -1);
      sample(12'd3500, -1);
      rd(4'd8, d); chk("R6 two of three", d, 0);
      sample(12'd3540, -1);
      rd(4'd8, d); chk("R6 alarm pending", d, 32'h2);
      chk("R9 masked irq", irq, 0);
      wr(4'd7, 32'h2); #1;
      chk("R9 irq enabled", irq, 1);
      wr(4'd8, 32'h2); #1;
      rd(4'd8, d); chk("R9 write-one clear", d, 0);
      chk("R9 irq after clear", irq, 0);
      sample(12'd3530, -1);
      rd(4'd8, d); chk("R7 no refire", d, 0);
      sample(12'd3700, -1);
      sample(12'd3520, -1);
      sample(12'd3520, -1);
      sample(12'd3520, -1);
      rd(4'd8, d); chk("R7 re-armed after cold", d, 32'h2);
      wr(4'd8, 32'h2);

      wr(4'd7, 32'h22);
      sample(12'd3437, -1);
      rd(4'd8, d); chk("R8 one shutdown sample", d, 0);
      chk("R8 ovt_rst low", ovt_rst, 0);
      sample(12'd3400, -1);
      rd(4'd8, d); chk("R8 shutdown pending", d, 32'h20);
      chk("R8 ovt_rst", ovt_rst, 1);
      chk("R8 ovt_pin", ovt_pin, 1);
      chk("R9 irq from shutdown", irq, 1);
      wr(4'd7, 32'h2); #1;
      chk("R8 pin unrouted", ovt_pin, 0);
      chk("R8 rst stays", ovt_rst, 1);
      chk("R9 irq shutdown masked", irq, 0);
      wr(4'd8, 32'h20); #1;
      chk("R9 shutdown cleared", ovt_rst, 0);
      sample(12'd3700, -1);

      // R10 disable during conversion
      sens_q.push_back(12'd3710);
      sc = start_cnt;
      wait (start_cnt != sc);
      sc = done_cnt;
      wr(4'd0, 32'h20);
      rd(4'd0, d); chk("R10 busy during wind-down", d, 32'h10020);
      wait (done_cnt != sc);
      @(negedge clk); #1;
      rd(4'd0, d); chk("R10 idle after done", d, 32'h20);
      rd(4'd9, d); chk("R10 last result kept", d, 3710);
      sc = start_cnt;
      repeat (60) @(negedge clk);
      chk("R10 no start after disable", start_cnt, sc);

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule